// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This unit sits between an integer core's execute stage and a byte-addressed, big-endian data memory. For each memory operation it adds the base register to the sign-extended 16-bit offset. It checks that the resulting address suits the access size and then issues a word-aligned memory request. The request carries per-lane byte enables, and for stores it also carries data placed on the right lanes. For loads, one cycle after the request it takes the read word from memory, picks out the addressed byte, halfword or word, and sign- or zero-extends the result into a write-back value.

The upper-immediate operation passes through the same pipeline without touching memory. Its write-back value is the 16-bit immediate placed in the top half of the result. A misaligned halfword or word access raises an address-error flag in place of the memory request, so memory is never touched and no write-back occurs. Any opcode outside the recognised set does nothing.

Top module: `lsu_align_be`

## Requirements
- R1: The effective address is `in_base` plus the sign-extended `in_offset`, with wrap modulo 2^ADDR_W. One cycle after an accepted load or store, `mem_req` is high and `mem_addr` is that address with its two low bits cleared. `mem_addr` and `mem_wdata` are zero whenever no request is made, and `mem_wdata` is zero for loads.
- R2: A byte access (opcode 0x24, 0x20 or 0x28) asserts exactly one enable. The enable is `mem_be[3 - a]`, where a is the low two address bits, so `mem_be[3]` is the lane of the lowest address and of bits 31:24. A byte store puts the store byte on all four lanes of `mem_wdata`.
- R3: A halfword access (opcodes 0x21, 0x25, 0x29) at address offset 0 enables `4'b1100`, and at offset 2 it enables `4'b0011`. A halfword store puts bits 15:0 of the store data on both halves of `mem_wdata`.
- R4: A word access (opcodes 0x23, 0x2b) with both low address bits zero enables `4'b1111`, and a word store drives the store data unchanged.
- R5: A halfword access at an odd address, or a word access whose low two address bits are not both zero, raises `addr_err` for one cycle. In that cycle `mem_req` is low and `mem_be` is zero. A byte access never raises `addr_err`.
- R6: Opcode 0x20 returns the addressed byte sign-extended and opcode 0x24 returns it zero-extended. The byte at offset a sits in bits (31-8a):(24-8a) of `mem_rdata`. `wb_valid` and `wb_data` appear two cycles after the operation is presented, computed from `mem_rdata` in that same cycle.
- R7: Opcode 0x21 returns a sign-extended halfword and opcode 0x25 returns a zero-extended halfword. The byte at the lower address is the upper byte of the result.
- R8: Opcode 0x23 returns the full word, with the byte at the lowest address in bits 31:24.
- R9: A misaligned load produces no `wb_valid`.
- R10: Opcode 0x0F produces `wb_valid` two cycles later with `wb_data = {in_offset, 16'h0}`, and makes no memory request.
- R11: When `in_valid` is low, or the opcode is not one of those above, there is no request, no address error and no write-back, so memory contents are unchanged.
- R12: While reset is active, and in the first cycle after it, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation presented this cycle |
| in_op | input | 6 | Primary opcode |
| in_base | input | ADDR_W | Base register value |
| in_offset | input | IMM_W | Signed offset, or immediate for the upper-immediate operation |
| in_sdata | input | DATA_W | Store data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_be | output | DATA_W/8 | Lane enables, MSB is the lowest address |
| mem_wdata | output | DATA_W | Write data on lanes |
| mem_rdata | input | DATA_W | Read word, valid the cycle after a read request |
| addr_err | output | 1 | Alignment error for the operation issued last cycle |
| wb_valid | output | 1 | Write-back value is valid |
| wb_data | output | DATA_W | Extended load data or upper-immediate value |

## Verification
The bench builds the unit with a 32-bit address, a 32-bit data path and a 16-bit offset. The four byte lanes make every byte offset and both halfword offsets reachable, and the full-width address lets negative offsets and wrap past the top of the address space be exercised. A 64-byte memory model in the bench answers requests, so stores followed at once by loads of the same word test the lane placement end to end.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_LD_BYTE_S = 6'h20;
  localparam logic [OPC_W-1:0] OPC_LD_HALF_S = 6'h21;
  localparam logic [OPC_W-1:0] OPC_LD_WORD   = 6'h23;
  localparam logic [OPC_W-1:0] OPC_LD_BYTE_U = 6'h24;
  localparam logic [OPC_W-1:0] OPC_LD_HALF_U = 6'h25;
  localparam logic [OPC_W-1:0] OPC_ST_BYTE   = 6'h28;
  localparam logic [OPC_W-1:0] OPC_ST_HALF   = 6'h29;
  localparam logic [OPC_W-1:0] OPC_ST_WORD   = 6'h2b;
  localparam logic [OPC_W-1:0] OPC_UPPER_IMM = 6'h0f;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      is_load;
    logic      is_store;
    logic      is_upper;
    logic      sign_ext;
    acc_size_e size;
  } op_info_t;

endpackage

// File: rtl/lsu_op_decode.sv
module lsu_op_decode
  import lsu_align_pkg::*;
(
  input  logic             valid_i,
  input  logic [OPC_W-1:0] op_i,
  output op_info_t         info_o
);

  always_comb begin
    info_o = '0;
    if (valid_i) begin
      case (op_i)
        OPC_LD_BYTE_S: begin info_o.is_load  = 1'b1; info_o.sign_ext = 1'b1; info_o.size = ACC_BYTE; end
        OPC_LD_BYTE_U: begin info_o.is_load  = 1'b1; info_o.size = ACC_BYTE; end
        OPC_LD_HALF_S: begin info_o.is_load  = 1'b1; info_o.sign_ext = 1'b1; info_o.size = ACC_HALF; end
        OPC_LD_HALF_U: begin info_o.is_load  = 1'b1; info_o.size = ACC_HALF; end
        OPC_LD_WORD:   begin info_o.is_load  = 1'b1; info_o.size = ACC_WORD; end
        OPC_ST_BYTE:   begin info_o.is_store = 1'b1; info_o.size = ACC_BYTE; end
        OPC_ST_HALF:   begin info_o.is_store = 1'b1; info_o.size = ACC_HALF; end
        OPC_ST_WORD:   begin info_o.is_store = 1'b1; info_o.size = ACC_WORD; end
        OPC_UPPER_IMM: begin info_o.is_upper = 1'b1; end
        default:       info_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lsu_align_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] low_i,
  output logic             misaligned_o
);

  always_comb begin
    case (size_i)
      ACC_HALF: misaligned_o = low_i[0];
      ACC_WORD: misaligned_o = |low_i;
      default:  misaligned_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_align_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int NB     = DATA_W / 8,
  localparam int OFF_W  = $clog2(NB)
) (
  input  acc_size_e         size_i,
  input  logic [OFF_W-1:0]  lane_i,
  input  logic [DATA_W-1:0] sdata_i,
  output logic [NB-1:0]     be_o,
  output logic [DATA_W-1:0] wdata_o
);

  // Lane g holds the byte at address offset g; it sits in the upper bits.
  for (genvar g = 0; g < NB; g++) begin : g_lane
    localparam int HI = DATA_W - 1 - 8 * g;
    logic       lane_en;
    logic [7:0] lane_byte;

    always_comb begin
      case (size_i)
        ACC_BYTE: begin
          lane_en   = (lane_i == OFF_W'(g));
          lane_byte = sdata_i[7:0];
        end
        ACC_HALF: begin
          lane_en   = (lane_i[OFF_W-1:1] == (OFF_W-1)'(g / 2));
          lane_byte = ((g % 2) == 0) ? sdata_i[15:8] : sdata_i[7:0];
        end
        default: begin
          lane_en   = 1'b1;
          lane_byte = sdata_i[HI -: 8];
        end
      endcase
    end

    assign be_o[NB-1-g]     = lane_en;
    assign wdata_o[HI -: 8] = lane_byte;
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int NB     = DATA_W / 8,
  localparam int OFF_W  = $clog2(NB)
) (
  input  acc_size_e         size_i,
  input  logic              sign_i,
  input  logic [OFF_W-1:0]  lane_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] value_o
);

  logic [7:0]  pick_b;
  logic [15:0] pick_h;

  always_comb begin
    pick_b = rdata_i[(DATA_W - 1 - 8 * int'(lane_i)) -: 8];
    pick_h = rdata_i[(DATA_W - 1 - 8 * int'(lane_i)) -: 16];
    case (size_i)
      ACC_BYTE: value_o = {{(DATA_W-8){sign_i & pick_b[7]}}, pick_b};
      ACC_HALF: value_o = {{(DATA_W-16){sign_i & pick_h[15]}}, pick_h};
      default:  value_o = rdata_i;
    endcase
  end

endmodule

// File: rtl/lsu_align_be.sv
module lsu_align_be
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [5:0]          in_op,
  input  logic [ADDR_W-1:0]   in_base,
  input  logic [IMM_W-1:0]    in_offset,
  input  logic [DATA_W-1:0]   in_sdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                addr_err,
  output logic                wb_valid,
  output logic [DATA_W-1:0]   wb_data
);

  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);

  // ---------------- reset release synchronizer ----------------
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  // ---------------- request-side combinational path ----------------
  op_info_t          info;
  logic [ADDR_W-1:0] eff_addr;
  logic [OFF_W-1:0]  lane;
  logic              misal;
  logic [NB-1:0]     be_raw;
  logic [DATA_W-1:0] wd_raw;

  assign eff_addr = in_base + {{(ADDR_W-IMM_W){in_offset[IMM_W-1]}}, in_offset};
  assign lane     = eff_addr[OFF_W-1:0];

  lsu_op_decode u_dec (
    .valid_i (in_valid),
    .op_i    (in_op),
    .info_o  (info)
  );

  lsu_align_check #(.OFF_W(OFF_W)) u_align (
    .size_i       (info.size),
    .low_i        (lane),
    .misaligned_o (misal)
  );

  lsu_store_lanes #(.DATA_W(DATA_W)) u_lanes (
    .size_i  (info.size),
    .lane_i  (lane),
    .sdata_i (in_sdata),
    .be_o    (be_raw),
    .wdata_o (wd_raw)
  );

  logic              nx_req, nx_we, nx_err, nx_ld, nx_upper;
  logic [ADDR_W-1:0] nx_addr;
  logic [NB-1:0]     nx_be;
  logic [DATA_W-1:0] nx_wdata, nx_upper_val;

  always_comb begin
    nx_req       = (info.is_load | info.is_store) & ~misal;
    nx_we        = info.is_store & ~misal;
    nx_err       = (info.is_load | info.is_store) & misal;
    nx_ld        = info.is_load & ~misal;
    nx_upper     = info.is_upper;
    nx_addr      = nx_req ? {eff_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} : '0;
    nx_be        = nx_req ? be_raw : '0;
    nx_wdata     = nx_we  ? wd_raw : '0;
    nx_upper_val = info.is_upper ? {in_offset, {(DATA_W-IMM_W){1'b0}}} : '0;
  end

  // ---------------- stage 1: memory request ----------------
  logic              s1_req, s1_we, s1_err, s1_ld, s1_upper, s1_sign;
  logic [ADDR_W-1:0] s1_addr;
  logic [NB-1:0]     s1_be;
  logic [DATA_W-1:0] s1_wdata, s1_upper_val;
  acc_size_e         s1_size;
  logic [OFF_W-1:0]  s1_lane;
  logic              s1_en;

  assign s1_en = in_valid | s1_req | s1_err | s1_upper;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      s1_req       <= 1'b0;
      s1_we        <= 1'b0;
      s1_err       <= 1'b0;
      s1_ld        <= 1'b0;
      s1_upper     <= 1'b0;
      s1_sign      <= 1'b0;
      s1_addr      <= '0;
      s1_be        <= '0;
      s1_wdata     <= '0;
      s1_upper_val <= '0;
      s1_size      <= ACC_BYTE;
      s1_lane      <= '0;
    end else if (s1_en) begin
      s1_req       <= nx_req;
      s1_we        <= nx_we;
      s1_err       <= nx_err;
      s1_ld        <= nx_ld;
      s1_upper     <= nx_upper;
      s1_sign      <= info.sign_ext;
      s1_addr      <= nx_addr;
      s1_be        <= nx_be;
      s1_wdata     <= nx_wdata;
      s1_upper_val <= nx_upper_val;
      s1_size      <= info.size;
      s1_lane      <= lane;
    end
  end

  // ---------------- stage 2: write-back ----------------
  logic              s2_ld, s2_upper, s2_sign;
  logic [DATA_W-1:0] s2_upper_val;
  acc_size_e         s2_size;
  logic [OFF_W-1:0]  s2_lane;
  logic              s2_en;

  assign s2_en = s1_ld | s1_upper | s2_ld | s2_upper;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      s2_ld        <= 1'b0;
      s2_upper     <= 1'b0;
      s2_sign      <= 1'b0;
      s2_upper_val <= '0;
      s2_size      <= ACC_BYTE;
      s2_lane      <= '0;
    end else if (s2_en) begin
      s2_ld        <= s1_ld;
      s2_upper     <= s1_upper;
      s2_sign      <= s1_sign;
      s2_upper_val <= s1_upper_val;
      s2_size      <= s1_size;
      s2_lane      <= s1_lane;
    end
  end

  logic [DATA_W-1:0] ld_value;

  lsu_load_extract #(.DATA_W(DATA_W)) u_extract (
    .size_i  (s2_size),
    .sign_i  (s2_sign),
    .lane_i  (s2_lane),
    .rdata_i (mem_rdata),
    .value_o (ld_value)
  );

  assign mem_req   = s1_req;
  assign mem_we    = s1_we;
  assign mem_addr  = s1_addr;
  assign mem_be    = s1_be;
  assign mem_wdata = s1_wdata;
  assign addr_err  = s1_err;
  assign wb_valid  = s2_ld | s2_upper;
  assign wb_data   = s2_upper ? s2_upper_val : (s2_ld ? ld_value : '0);

endmodule

// File: rtl/lsu_align_be_chk.sv
module lsu_align_be_chk
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [5:0]          in_op,
  input logic [ADDR_W-1:0]   in_base,
  input logic [IMM_W-1:0]    in_offset,
  input logic                mem_req,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W/8-1:0] mem_be,
  input logic                addr_err,
  input logic                wb_valid,
  input logic [DATA_W-1:0]   wb_data
);

  logic [2:0]        age;
  logic              age_ok;
  logic [ADDR_W-1:0] ea;
  logic [DATA_W-1:0] upper_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age <= '0;
    else if (age != 3'd7)   age <= age + 3'd1;
  end

  assign age_ok    = (age >= 3'd4);
  assign ea        = in_base + {{(ADDR_W-IMM_W){in_offset[IMM_W-1]}}, in_offset};
  assign upper_val = {in_offset, {(DATA_W-IMM_W){1'b0}}};

  AST_ERR_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (!mem_req && mem_be == '0)); // R5

  AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (age_ok && $past(in_valid) && $past(in_op) == OPC_LD_WORD && mem_req)
      |-> mem_addr == {$past(ea[ADDR_W-1:2]), 2'b00}); // R1

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (age_ok && $past(in_valid) && ($past(in_op) == OPC_ST_BYTE || $past(in_op) == OPC_LD_BYTE_S))
      |-> $countones(mem_be) == 1); // R2

  AST_UPPER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (age_ok && $past(in_valid, 2) && $past(in_op, 2) == OPC_UPPER_IMM)
      |-> (wb_valid && wb_data == $past(upper_val, 2))); // R10

  AST_MISALIGNED_LOAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (age_ok && $past(in_valid, 2) && $past(in_op, 2) == OPC_LD_WORD && $past(ea[1:0], 2) != 2'b00)
      |-> !wb_valid); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (age_ok && !$past(in_valid)) |-> (!mem_req && !addr_err)); // R11

endmodule

bind lsu_align_be lsu_align_be_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .IMM_W  (IMM_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .in_base   (in_base),
  .in_offset (in_offset),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .addr_err  (addr_err),
  .wb_valid  (wb_valid),
  .wb_data   (wb_data)
);

// File: tb/lsu_align_be_tb_top.sv
module lsu_align_be_tb_top;

  localparam int RAM_N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [5:0]  in_op = '0;
  logic [31:0] in_base = '0;
  logic [15:0] in_offset = '0;
  logic [31:0] in_sdata = '0;
  logic [31:0] mem_rdata = '0;

  logic        mem_req, mem_we, addr_err, wb_valid;
  logic [31:0] mem_addr, mem_wdata, wb_data;
  logic [3:0]  mem_be;

  always #5 clk = ~clk;

  lsu_align_be #(.ADDR_W(32), .DATA_W(32), .IMM_W(16)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_base   (in_base),
    .in_offset (in_offset),
    .in_sdata  (in_sdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .addr_err  (addr_err),
    .wb_valid  (wb_valid),
    .wb_data   (wb_data)
  );

  // Memory the design talks to, and a model image updated in program order.
  logic [7:0] ram    [RAM_N];
  logic [7:0] shadow [RAM_N];

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[3-k]) ram[int'(mem_addr[5:0]) + k] <= mem_wdata[31-8*k -: 8];
      end else begin
        mem_rdata <= {ram[int'(mem_addr[5:0])],     ram[int'(mem_addr[5:0]) + 1],
                      ram[int'(mem_addr[5:0]) + 2], ram[int'(mem_addr[5:0]) + 3]};
      end
    end
  end

  typedef struct {
    bit          req;
    bit          we;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    bit          err;
    string       tag;
  } req_exp_t;

  typedef struct {
    bit          valid;
    logic [31:0] data;
    string       tag;
  } wb_exp_t;

  req_exp_t q_req[$];
  wb_exp_t  q_wb[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_cycle();
    req_exp_t r;
    wb_exp_t  w;
    r = q_req.pop_front();
    w = q_wb.pop_front();
    chk(mem_req === r.req && mem_we === r.we, r.tag, "req/we",
        {30'b0, mem_req, mem_we}, {30'b0, r.req, r.we});
    chk(mem_addr === r.addr, r.tag, "addr", mem_addr, r.addr);
    chk(mem_be === r.be, r.tag, "be", {28'b0, mem_be}, {28'b0, r.be});
    chk(mem_wdata === r.wdata, r.tag, "wdata", mem_wdata, r.wdata);
    chk(addr_err === r.err, r.tag, "addr_err", {31'b0, addr_err}, {31'b0, r.err});
    chk(wb_valid === w.valid, w.tag, "wb_valid", {31'b0, wb_valid}, {31'b0, w.valid});
    chk(wb_data === w.data, w.tag, "wb_data", wb_data, w.data);
  endtask

  task automatic issue(bit v, logic [5:0] op, logic [31:0] base, logic [15:0] off, logic [31:0] sd);
    req_exp_t    r;
    wb_exp_t     w;
    logic [31:0] ea, val, tmp;
    int          sz, idx, ln;
    bit          ld, st, sg;
    @(negedge clk);
    compare_cycle();
    in_valid  = v;
    in_op     = op;
    in_base   = base;
    in_offset = off;
    in_sdata  = sd;
    r = '{req: 0, we: 0, addr: '0, be: '0, wdata: '0, err: 0, tag: "R11"};
    w = '{valid: 0, data: '0, tag: "R11"};
    ea = base + {{16{off[15]}}, off};
    ld = 0; st = 0; sg = 0; sz = 0;
    if (v) begin
      case (op)
        6'h20: begin ld = 1; sz = 1; sg = 1; end
        6'h24: begin ld = 1; sz = 1; end
        6'h21: begin ld = 1; sz = 2; sg = 1; end
        6'h25: begin ld = 1; sz = 2; end
        6'h23: begin ld = 1; sz = 4; end
        6'h28: begin st = 1; sz = 1; end
        6'h29: begin st = 1; sz = 2; end
        6'h2b: begin st = 1; sz = 4; end
        6'h0f: w = '{valid: 1, data: {off, 16'h0000}, tag: "R10"};
        default: ;
      endcase
    end
    if (ld || st) begin
      if ((ea % sz) != 0) begin
        r.err = 1;
        r.tag = "R5";
        if (ld) w.tag = "R9";
      end else begin
        r.req  = 1;
        r.we   = st;
        r.addr = ea & ~32'h3;
        for (int j = 0; j < sz; j++) begin
          ln = int'(ea[1:0]) + j;
          r.be[3-ln] = 1'b1;
        end
        if (sz == 1)      r.tag = "R1 R2";
        else if (sz == 2) r.tag = "R1 R3";
        else              r.tag = "R1 R4";
        idx = int'(ea[5:0]);
        if (st) begin
          if (sz == 1)      r.wdata = {4{sd[7:0]}};
          else if (sz == 2) r.wdata = {2{sd[15:0]}};
          else              r.wdata = sd;
          for (int j = 0; j < sz; j++) begin
            tmp = sd >> (8 * (sz - 1 - j));
            shadow[idx + j] = tmp[7:0];
          end
        end else begin
          val = '0;
          for (int j = 0; j < sz; j++) val = (val << 8) | {24'h0, shadow[idx + j]};
          if (sg && sz == 1) val = {{24{val[7]}}, val[7:0]};
          if (sg && sz == 2) val = {{16{val[15]}}, val[15:0]};
          w.valid = 1;
          w.data  = val;
          if (sz == 1)      w.tag = "R6";
          else if (sz == 2) w.tag = "R7";
          else              w.tag = "R8";
        end
      end
    end
    q_req.push_back(r);
    q_wb.push_back(w);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (R1..R12 not completed): actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < RAM_N; i++) begin
      ram[i]    = 8'(i * 29 + 7);
      shadow[i] = 8'(i * 29 + 7);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: outputs quiet while reset is held
    chk({mem_req, mem_we, addr_err, wb_valid} === 4'b0 && mem_be === 4'b0 &&
        mem_addr === 32'h0 && mem_wdata === 32'h0 && wb_data === 32'h0,
        "R12", "outputs in reset", {28'b0, mem_req, mem_we, addr_err, wb_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    q_req.push_back('{req: 0, we: 0, addr: '0, be: '0, wdata: '0, err: 0, tag: "R12"});
    q_wb.push_back('{valid: 0, data: '0, tag: "R12"});
    q_wb.push_back('{valid: 0, data: '0, tag: "R12"});

    // R8 with initial contents, then store/load words (R4)
    issue(1, 6'h23, 32'h100, 16'h0004, 32'h0);
    issue(1, 6'h2b, 32'h100, 16'h0008, 32'h11223344);
    issue(1, 6'h23, 32'h100, 16'h0008, 32'h0);
    // R2: byte stores on every lane
    for (int k = 0; k < 4; k++)
      issue(1, 6'h28, 32'h10C, 16'(k), 32'hFFFFFF00 | 32'(8'h85 + 8'(k * 8'h30)));
    issue(1, 6'h23, 32'h10C, 16'h0000, 32'h0);
    // R6: signed and unsigned bytes at every offset
    for (int k = 0; k < 4; k++) begin
      issue(1, 6'h20, 32'h10C, 16'(k), 32'h0);
      issue(1, 6'h24, 32'h10C, 16'(k), 32'h0);
    end
    // R3 / R7: halfwords at both offsets
    issue(1, 6'h29, 32'h110, 16'h0000, 32'hAAAABEEF);
    issue(1, 6'h29, 32'h110, 16'h0002, 32'h55551234);
    issue(1, 6'h23, 32'h110, 16'h0000, 32'h0);
    issue(1, 6'h21, 32'h110, 16'h0000, 32'h0);
    issue(1, 6'h25, 32'h110, 16'h0000, 32'h0);
    issue(1, 6'h21, 32'h110, 16'h0002, 32'h0);
    issue(1, 6'h25, 32'h110, 16'h0002, 32'h0);
    // R5 / R9: misaligned accesses, then confirm memory untouched
    issue(1, 6'h29, 32'h111, 16'h0000, 32'hDEADBEEF);
    issue(1, 6'h2b, 32'h108, 16'h0002, 32'hDEADBEEF);
    issue(1, 6'h2b, 32'h108, 16'h0001, 32'hDEADBEEF);
    issue(1, 6'h21, 32'h113, 16'h0000, 32'h0);
    issue(1, 6'h23, 32'h10E, 16'h0000, 32'h0);
    issue(1, 6'h25, 32'h101, 16'h0000, 32'h0);
    issue(1, 6'h20, 32'h103, 16'h0000, 32'h0);
    issue(1, 6'h23, 32'h108, 16'h0000, 32'h0);
    issue(1, 6'h23, 32'h110, 16'h0000, 32'h0);
    // R10: upper immediate, both halves of the immediate range
    issue(1, 6'h0f, 32'h0, 16'h1234, 32'h0);
    issue(1, 6'h0f, 32'hFFFF, 16'h8001, 32'hFFFFFFFF);
    // R11: unknown opcodes and an invalid store leave everything quiet
    issue(1, 6'h22, 32'h108, 16'h0000, 32'hDEADBEEF);
    issue(1, 6'h26, 32'h108, 16'h0000, 32'hDEADBEEF);
    issue(1, 6'h00, 32'h108, 16'h0000, 32'hDEADBEEF);
    issue(0, 6'h2b, 32'h108, 16'h0000, 32'hDEADBEEF);
    issue(1, 6'h23, 32'h108, 16'h0000, 32'h0);
    // R1: negative offset and wrap past the top of the address space
    issue(1, 6'h23, 32'h10000120, 16'hFFF0, 32'h0);
    issue(1, 6'h23, 32'hFFFFFFFC, 16'h0008, 32'h0);
    issue(1, 6'h28, 32'h00000005, 16'hFFFF, 32'h0000007E);
    // back-to-back store then load of the same word
    issue(1, 6'h2b, 32'h118, 16'h0000, 32'hCAFEF00D);
    issue(1, 6'h23, 32'h118, 16'h0000, 32'h0);
    issue(1, 6'h0f, 32'h0, 16'hFFFF, 32'h0);
    issue(1, 6'h20, 32'h118, 16'h0001, 32'h0);
    issue(1, 6'h23, 32'h004, 16'h0000, 32'h0);
    // drain
    issue(0, 6'h00, 32'h0, 16'h0, 32'h0);
    issue(0, 6'h00, 32'h0, 16'h0, 32'h0);
    issue(0, 6'h00, 32'h0, 16'h0, 32'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule